// File: doc/BRIEF.md
# MMIO Window to Partition Mapper

This block is a table of address windows that turns an incoming MMIO address into a partition number. Each window is stored as a base and a mask. The mask must be a run of ones from the top bit down. As a result every window is a power-of-two range, aligned to its own size. Let k be the number of trailing zero bits in the mask. The window then spans 2^k bytes. When a window is cut into segments, the segment index is taken from the address bits just below bit k.

Each window runs in one of four translations:
- **Shared segmented:** segment n selects partition n.
- **Whole-window:** the entire range selects one programmed partition.
- **Per-segment table:** each of 8 segments looks up its own programmable partition.
- **Base-offset:** 8, 64 or 128 segments, where segment n selects partition base + n.

An entry write port programs whole entries. Each write is checked before it is committed, and a bad write is refused. A second write port fills the per-segment tables. The lookup port returns a registered result one cycle after the request: a hit flag, the partition number and the index of the winning window.

Top module: `mmio_part_map`

## Requirements
- R1: A lookup presented with `lk_valid` high produces `res_valid` high on the next clock, with `res_hit`, `res_part` and `res_win` for that address; `res_valid` is low otherwise.
- R2: A window matches when it is enabled and `((addr ^ base) & mask) == 0`; a lookup with no matching window returns `res_hit`=0, `res_part`=0 and `res_win`=0.
- R3: When several enabled windows match, the lowest-numbered window supplies the result.
- R4: Mode code 0 (shared segmented) returns partition = address bits [k-1:k-8] with the default 8-bit partition number.
- R5: Mode code 1 (whole-window) returns the programmed partition. A write of this mode with k below 25 (window under 32 MB) is rejected.
- R6: Mode code 2 (per-segment table) returns the table entry selected by address bits [k-1:k-3]. `seg_we` writes entry `seg_idx` of window `seg_win` at any time, and the change is visible to the next lookup.
- R7: Mode code 3 (base-offset) takes its segment count from count code 0, 1 or 2 (8, 64 or 128 segments; code 3 is rejected). It returns the programmed base plus the segment index. A base that is not a multiple of the segment count is rejected.
- R8: Enable code 0 disables the window and is always accepted. Code 1 (split) is accepted only with the segmented modes 0, 2 and 3. Code 2 (non-split) is accepted only with mode 1. Code 3 is always rejected.
- R9: A write that enables a window is rejected if any of these hold: the mask is not contiguous from the top bit; the base has a bit set below the mask boundary; or the window is smaller than its segment count (k below 8, 3 or the base-offset segment log).
- R10: A rejected entry write leaves the entry unchanged and raises `cfg_err` for exactly the one cycle after the write. An accepted write leaves `cfg_err` low.
- R11: After reset all windows are disabled and `res_valid`, `res_hit` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | 4 | Window index to write |
| ent_base | input | 40 | Window base address |
| ent_mask | input | 40 | Window compare mask |
| ent_mode | input | 2 | Translation mode code |
| ent_en | input | 2 | Enable code |
| ent_part | input | 8 | Partition (whole-window) or base partition (base-offset) |
| ent_scnt | input | 2 | Base-offset segment count code |
| cfg_err | output | 1 | Rejected entry write, one-cycle pulse |
| seg_we | input | 1 | Per-segment table write strobe |
| seg_win | input | 4 | Window whose table is written |
| seg_idx | input | 3 | Table entry index |
| seg_part | input | 8 | Partition stored in the table entry |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 40 | Lookup address |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window matched |
| res_part | output | 8 | Resolved partition number |
| res_win | output | 4 | Index of the winning window |

## Verification
A wrong stored field in a window shows on the very next lookup that lands in that window. A corrupted base or mask makes the window miss, or makes it claim addresses outside its range. A wrong mode, k or count code shifts the segment bits and so changes `res_part`. Each case appears one cycle after the request. A refused write that still reached storage is caught by looking up an address that only the old entry covers. A broken priority order shows as the wrong `res_win` for an address inside two overlapping windows.

// File: rtl/mpm_pkg.sv
`timescale 1ns/1ps
package mpm_pkg;

   typedef enum logic [1:0] {
      MODE_SHARED = 2'd0,
      MODE_WHOLE  = 2'd1,
      MODE_TABLE  = 2'd2,
      MODE_OFFSET = 2'd3
   } mode_e;

   typedef enum logic [1:0] {
      EN_OFF   = 2'd0,
      EN_SPLIT = 2'd1,
      EN_WHOLE = 2'd2,
      EN_BAD   = 2'd3
   } en_e;

   // log2 of segment count for the base-offset mode, 0 for an illegal code
   function automatic int unsigned offset_log(input logic [1:0] code);
      case (code)
         2'd0:    return 3;
         2'd1:    return 6;
         2'd2:    return 7;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/mpm_entry_check.sv
`timescale 1ns/1ps
module mpm_entry_check
   import mpm_pkg::*;
#(
   parameter int ADDR_W        = 40,
   parameter int PART_W        = 8,
   parameter int TBL_LOG       = 3,
   parameter int MIN_WHOLE_LOG = 25,
   parameter bit HAS_TABLE     = 1'b1,
   localparam int TZ_W         = $clog2(ADDR_W + 1)
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] mask,
   input  logic [1:0]        mode,
   input  logic [1:0]        en,
   input  logic [PART_W-1:0] part,
   input  logic [1:0]        scnt,
   output logic              ok,
   output logic [TZ_W-1:0]   k
);

   localparam logic [ADDR_W-1:0] ONES_A  = {ADDR_W{1'b1}};
   localparam logic [PART_W-1:0] ONES_P  = {PART_W{1'b1}};
   localparam logic [TZ_W-1:0]   K_PART  = TZ_W'(PART_W);
   localparam logic [TZ_W-1:0]   K_TBL   = TZ_W'(TBL_LOG);
   localparam logic [TZ_W-1:0]   K_WHOLE = TZ_W'(MIN_WHOLE_LOG);

   logic              contig, aligned;
   logic [TZ_W-1:0]   off_log;
   logic [PART_W-1:0] off_msk;

   always_comb begin
      k = TZ_W'(ADDR_W);
      for (int i = ADDR_W - 1; i >= 0; i--) begin
         if (mask[i]) k = TZ_W'(i);
      end
   end

   assign contig  = (mask == (ONES_A << k));
   assign aligned = ((base & ~mask) == '0);
   assign off_log = TZ_W'(offset_log(scnt));
   assign off_msk = ONES_P >> (PART_W - int'(off_log));

   always_comb begin
      ok = 1'b0;
      if (en_e'(en) == EN_OFF) begin
         ok = 1'b1;
      end else if (contig && aligned) begin
         case (mode_e'(mode))
            MODE_WHOLE:  ok = (en_e'(en) == EN_WHOLE) && (k >= K_WHOLE);
            MODE_SHARED: ok = (en_e'(en) == EN_SPLIT) && (k >= K_PART);
            MODE_TABLE:  ok = HAS_TABLE && (en_e'(en) == EN_SPLIT) && (k >= K_TBL);
            MODE_OFFSET: ok = (en_e'(en) == EN_SPLIT) && (scnt != 2'd3) &&
                              (k >= off_log) && ((part & off_msk) == '0);
            default:     ok = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/mpm_window.sv
`timescale 1ns/1ps
module mpm_window
   import mpm_pkg::*;
#(
   parameter int ADDR_W        = 40,
   parameter int PART_W        = 8,
   parameter int TBL_LOG       = 3,
   parameter int MIN_WHOLE_LOG = 25,
   parameter bit HAS_TABLE     = 1'b1,
   localparam int TZ_W         = $clog2(ADDR_W + 1),
   localparam int TBL_N        = 1 << TBL_LOG
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               ok,
   input  logic [TZ_W-1:0]    wr_k,
   input  logic [ADDR_W-1:0]  wr_base,
   input  logic [ADDR_W-1:0]  wr_mask,
   input  logic [1:0]         wr_mode,
   input  logic [1:0]         wr_en,
   input  logic [PART_W-1:0]  wr_part,
   input  logic [1:0]         wr_scnt,
   input  logic               tbl_we,
   input  logic [TBL_LOG-1:0] tbl_idx,
   input  logic [PART_W-1:0]  tbl_part,
   input  logic [ADDR_W-1:0]  lk_addr,
   output logic               hit,
   output logic [PART_W-1:0]  part
);

   localparam logic [PART_W-1:0] ONES_P = {PART_W{1'b1}};

   logic [ADDR_W-1:0] base_q, mask_q;
   mode_e             mode_q;
   en_e               en_q;
   logic [PART_W-1:0] part_q;
   logic [1:0]        scnt_q;
   logic [TZ_W-1:0]   k_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         mode_q <= MODE_SHARED;
         en_q   <= EN_OFF;
         part_q <= '0;
         scnt_q <= '0;
         k_q    <= '0;
      end else if (wr && ok) begin
         en_q <= en_e'(wr_en);
         if (en_e'(wr_en) != EN_OFF) begin
            base_q <= wr_base;
            mask_q <= wr_mask;
            mode_q <= mode_e'(wr_mode);
            part_q <= wr_part;
            scnt_q <= wr_scnt;
            k_q    <= wr_k;
         end
      end
   end

   // per-segment partition table, present only when the variant is built
   logic [PART_W-1:0] tbl_out;
   logic [ADDR_W-1:0] shifted;

   generate
      if (HAS_TABLE) begin : g_tbl
         logic [PART_W-1:0] tbl_q [TBL_N];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < TBL_N; i++) tbl_q[i] <= '0;
            end else if (tbl_we) begin
               tbl_q[tbl_idx] <= tbl_part;
            end
         end
         assign tbl_out = tbl_q[shifted[TBL_LOG-1:0]];
      end else begin : g_no_tbl
         assign tbl_out = '0;
      end
   endgenerate

   logic [TZ_W-1:0]   seg_log;
   logic [PART_W-1:0] seg;

   always_comb begin
      case (mode_q)
         MODE_SHARED: seg_log = TZ_W'(PART_W);
         MODE_TABLE:  seg_log = TZ_W'(TBL_LOG);
         MODE_OFFSET: seg_log = TZ_W'(offset_log(scnt_q));
         default:     seg_log = '0;
      endcase
   end

   assign shifted = lk_addr >> (k_q - seg_log);
   assign seg     = shifted[PART_W-1:0] & (ONES_P >> (PART_W - int'(seg_log)));
   assign hit     = (en_q != EN_OFF) && (((lk_addr ^ base_q) & mask_q) == '0);

   always_comb begin
      case (mode_q)
         MODE_SHARED: part = seg;
         MODE_WHOLE:  part = part_q;
         MODE_TABLE:  part = tbl_out;
         MODE_OFFSET: part = part_q + seg;
         default:     part = '0;
      endcase
   end

   a_r5_whole_min_size: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == EN_WHOLE) |-> (k_q >= TZ_W'(MIN_WHOLE_LOG)));

   a_r7_offset_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q != EN_OFF && mode_q == MODE_OFFSET) |->
      ((part_q & (ONES_P >> (PART_W - offset_log(scnt_q)))) == '0));

   a_r10_reject_keeps_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !ok) |=> ($stable(base_q) && $stable(mask_q) && $stable(en_q) &&
                       $stable(part_q) && $stable(mode_q)));

endmodule

// File: rtl/mpm_pick.sv
`timescale 1ns/1ps
module mpm_pick #(
   parameter int NUM_WIN  = 16,
   parameter int PART_W   = 8,
   localparam int WIN_W   = $clog2(NUM_WIN)
) (
   input  logic [NUM_WIN-1:0]             hits,
   input  logic [NUM_WIN-1:0][PART_W-1:0] parts,
   output logic                           any,
   output logic [PART_W-1:0]              part,
   output logic [WIN_W-1:0]               idx
);

   // walk from the top so the lowest matching index is the last assignment
   always_comb begin
      any  = 1'b0;
      part = '0;
      idx  = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hits[i]) begin
            any  = 1'b1;
            part = parts[i];
            idx  = WIN_W'(i);
         end
      end
   end

endmodule

// File: rtl/mmio_part_map.sv
`timescale 1ns/1ps
module mmio_part_map
   import mpm_pkg::*;
#(
   parameter int ADDR_W        = 40,
   parameter int NUM_WIN       = 16,
   parameter int PART_W        = 8,
   parameter int TBL_LOG       = 3,
   parameter int MIN_WHOLE_LOG = 25,
   parameter bit HAS_TABLE     = 1'b1,
   localparam int WIN_W        = $clog2(NUM_WIN),
   localparam int TZ_W         = $clog2(ADDR_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ent_we,
   input  logic [WIN_W-1:0]   ent_idx,
   input  logic [ADDR_W-1:0]  ent_base,
   input  logic [ADDR_W-1:0]  ent_mask,
   input  logic [1:0]         ent_mode,
   input  logic [1:0]         ent_en,
   input  logic [PART_W-1:0]  ent_part,
   input  logic [1:0]         ent_scnt,
   output logic               cfg_err,
   input  logic               seg_we,
   input  logic [WIN_W-1:0]   seg_win,
   input  logic [TBL_LOG-1:0] seg_idx,
   input  logic [PART_W-1:0]  seg_part,
   input  logic               lk_valid,
   input  logic [ADDR_W-1:0]  lk_addr,
   output logic               res_valid,
   output logic               res_hit,
   output logic [PART_W-1:0]  res_part,
   output logic [WIN_W-1:0]   res_win
);

   generate
      if (NUM_WIN < 2)                 begin : g_chk_win  $error("NUM_WIN must be at least 2");         end
      if (PART_W < 7)                  begin : g_chk_part $error("PART_W must cover 128 segments");     end
      if (ADDR_W <= MIN_WHOLE_LOG)     begin : g_chk_min  $error("ADDR_W must exceed MIN_WHOLE_LOG");  end
      if (TBL_LOG < 1 || TBL_LOG > PART_W) begin : g_chk_tbl $error("TBL_LOG out of range");         end
   endgenerate

   logic            ok;
   logic [TZ_W-1:0] k;

   mpm_entry_check #(
      .ADDR_W(ADDR_W), .PART_W(PART_W), .TBL_LOG(TBL_LOG),
      .MIN_WHOLE_LOG(MIN_WHOLE_LOG), .HAS_TABLE(HAS_TABLE)
   ) u_check (
      .base(ent_base), .mask(ent_mask), .mode(ent_mode), .en(ent_en),
      .part(ent_part), .scnt(ent_scnt), .ok(ok), .k(k)
   );

   logic [NUM_WIN-1:0]             hits;
   logic [NUM_WIN-1:0][PART_W-1:0] parts;

   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         mpm_window #(
            .ADDR_W(ADDR_W), .PART_W(PART_W), .TBL_LOG(TBL_LOG),
            .MIN_WHOLE_LOG(MIN_WHOLE_LOG), .HAS_TABLE(HAS_TABLE)
         ) u_win (
            .clk(clk), .rst_n(rst_n),
            .wr(ent_we && (ent_idx == WIN_W'(w))), .ok(ok), .wr_k(k),
            .wr_base(ent_base), .wr_mask(ent_mask), .wr_mode(ent_mode),
            .wr_en(ent_en), .wr_part(ent_part), .wr_scnt(ent_scnt),
            .tbl_we(seg_we && (seg_win == WIN_W'(w))), .tbl_idx(seg_idx),
            .tbl_part(seg_part), .lk_addr(lk_addr),
            .hit(hits[w]), .part(parts[w])
         );
      end
   endgenerate

   logic              any;
   logic [PART_W-1:0] pick_part;
   logic [WIN_W-1:0]  pick_idx;

   mpm_pick #(.NUM_WIN(NUM_WIN), .PART_W(PART_W)) u_pick (
      .hits(hits), .parts(parts), .any(any), .part(pick_part), .idx(pick_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_part  <= '0;
         res_win   <= '0;
         cfg_err   <= 1'b0;
      end else begin
         res_valid <= lk_valid;
         res_hit   <= lk_valid && any;
         res_part  <= (lk_valid && any) ? pick_part : '0;
         res_win   <= (lk_valid && any) ? pick_idx : '0;
         cfg_err   <= ent_we && !ok;
      end
   end

   a_r2_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_part == '0 && res_win == '0));

   a_r10_err_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(ent_we));

   a_r1_no_hit_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid);

endmodule

// File: tb/sim_mmio_part_map.sv
`timescale 1ns/1ps
module sim_mmio_part_map;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ent_we = 1'b0;
   logic [3:0]  ent_idx = '0;
   logic [39:0] ent_base = '0, ent_mask = '0;
   logic [1:0]  ent_mode = '0, ent_en = '0, ent_scnt = '0;
   logic [7:0]  ent_part = '0;
   logic        cfg_err;
   logic        seg_we = 1'b0;
   logic [3:0]  seg_win = '0;
   logic [2:0]  seg_idx = '0;
   logic [7:0]  seg_part = '0;
   logic        lk_valid = 1'b0;
   logic [39:0] lk_addr = '0;
   logic        res_valid, res_hit;
   logic [7:0]  res_part;
   logic [3:0]  res_win;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   mmio_part_map u0 (
      .clk(clk), .rst_n(rst_n),
      .ent_we(ent_we), .ent_idx(ent_idx), .ent_base(ent_base), .ent_mask(ent_mask),
      .ent_mode(ent_mode), .ent_en(ent_en), .ent_part(ent_part), .ent_scnt(ent_scnt),
      .cfg_err(cfg_err),
      .seg_we(seg_we), .seg_win(seg_win), .seg_idx(seg_idx), .seg_part(seg_part),
      .lk_valid(lk_valid), .lk_addr(lk_addr),
      .res_valid(res_valid), .res_hit(res_hit), .res_part(res_part), .res_win(res_win)
   );

   task automatic chk(input bit good, input string req, input longint act, input longint exp);
      n_run++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_ent(input int w, input logic [39:0] b, input logic [39:0] m,
                         input logic [1:0] mode, input logic [1:0] en,
                         input logic [7:0] p, input logic [1:0] sc,
                         input logic exp_err, input string req);
      @(negedge clk);
      ent_we = 1'b1; ent_idx = 4'(w); ent_base = b; ent_mask = m;
      ent_mode = mode; ent_en = en; ent_part = p; ent_scnt = sc;
      @(negedge clk);
      ent_we = 1'b0;
      chk(cfg_err == exp_err, req, longint'(cfg_err), longint'(exp_err));
   endtask

   task automatic wr_seg(input int w, input int i, input logic [7:0] p);
      @(negedge clk);
      seg_we = 1'b1; seg_win = 4'(w); seg_idx = 3'(i); seg_part = p;
      @(negedge clk);
      seg_we = 1'b0;
   endtask

   task automatic look(input logic [39:0] a, input logic h, input logic [7:0] p,
                       input logic [3:0] w, input string req);
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = a;
      @(negedge clk);
      lk_valid = 1'b0;
      chk(res_valid == 1'b1, {req, " valid"}, longint'(res_valid), 1);
      chk(res_hit == h && res_part == p && res_win == w, req,
          longint'({res_hit, res_part, res_win}), longint'({h, p, w}));
   endtask

   typedef struct packed {
      logic [39:0] a;
      logic        h;
      logic [7:0]  p;
      logic [3:0]  w;
   } vec_t;

   // R4 shared, R5 whole, R6 table, R7 offset, R3 overlap, R2 miss
   localparam vec_t VEC [14] = '{
      '{40'h10_AB00_0000, 1'b1, 8'hAB, 4'd0},
      '{40'h10_0000_0000, 1'b1, 8'h00, 4'd0},
      '{40'h10_FFFF_FFFF, 1'b1, 8'hFF, 4'd0},
      '{40'h20_01FF_FFFF, 1'b1, 8'h5A, 4'd1},
      '{40'h20_0200_0000, 1'b0, 8'h00, 4'd0},
      '{40'h30_000A_0000, 1'b1, 8'h95, 4'd2},
      '{40'h30_000F_FFFF, 1'b1, 8'h97, 4'd2},
      '{40'h40_0000_0000, 1'b1, 8'h40, 4'd3},
      '{40'h40_00FC_0000, 1'b1, 8'h7F, 4'd3},
      '{40'h60_000F_E000, 1'b1, 8'hFF, 4'd10},
      '{40'h70_0000_E000, 1'b1, 8'h0F, 4'd11},
      '{40'h50_0000_1000, 1'b1, 8'h11, 4'd4},
      '{40'h50_2000_0000, 1'b1, 8'h22, 4'd5},
      '{40'h00_0000_0000, 1'b0, 8'h00, 4'd0}
   };

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(res_valid == 1'b0 && res_hit == 1'b0, "R11 outputs idle", longint'({res_valid, res_hit}), 0);
      chk(cfg_err == 1'b0, "R11 no error", longint'(cfg_err), 0);
      look(40'h10_AB00_0000, 1'b0, 8'h00, 4'd0, "R11 windows disabled");

      // accepted programming (mode 0 shared,1 whole,2 table,3 offset; en 1 split,2 whole)
      wr_ent(0,  40'h10_0000_0000, 40'hFF_0000_0000, 2'd0, 2'd1, 8'h00, 2'd0, 1'b0, "R4 program");
      wr_ent(1,  40'h20_0000_0000, 40'hFF_FE00_0000, 2'd1, 2'd2, 8'h5A, 2'd0, 1'b0, "R5 program");
      wr_ent(2,  40'h30_0000_0000, 40'hFF_FFF0_0000, 2'd2, 2'd1, 8'h00, 2'd0, 1'b0, "R6 program");
      for (int i = 0; i < 8; i++) wr_seg(2, i, 8'(8'h90 + i));
      wr_ent(3,  40'h40_0000_0000, 40'hFF_FF00_0000, 2'd3, 2'd1, 8'h40, 2'd1, 1'b0, "R7 program 64");
      wr_ent(4,  40'h50_0000_0000, 40'hFF_F000_0000, 2'd1, 2'd2, 8'h11, 2'd0, 1'b0, "R3 program low");
      wr_ent(5,  40'h50_0000_0000, 40'hFF_C000_0000, 2'd1, 2'd2, 8'h22, 2'd0, 1'b0, "R3 program high");
      wr_ent(10, 40'h60_0000_0000, 40'hFF_FFF0_0000, 2'd3, 2'd1, 8'h80, 2'd2, 1'b0, "R7 program 128");
      wr_ent(11, 40'h70_0000_0000, 40'hFF_FFFF_0000, 2'd3, 2'd1, 8'h08, 2'd0, 1'b0, "R7 program 8");

      // R1 latency and table walk
      for (int i = 0; i < 14; i++)
         look(VEC[i].a, VEC[i].h, VEC[i].p, VEC[i].w, $sformatf("R1 R2 R3 vector %0d", i));

      // R5 too small whole-window window
      wr_ent(6, 40'h90_0000_0000, 40'hFF_FF00_0000, 2'd1, 2'd2, 8'h33, 2'd0, 1'b1, "R5 reject small");
      look(40'h90_0000_0000, 1'b0, 8'h00, 4'd0, "R5 small window absent");
      // R7 misaligned base partition and bad count code
      wr_ent(7, 40'h88_0000_0000, 40'hFF_FF00_0000, 2'd3, 2'd1, 8'h41, 2'd1, 1'b1, "R7 reject base");
      wr_ent(7, 40'h88_0000_0000, 40'hFF_FF00_0000, 2'd3, 2'd1, 8'h00, 2'd3, 1'b1, "R7 reject code3");
      look(40'h88_0000_0000, 1'b0, 8'h00, 4'd0, "R7 rejected window absent");
      // R8 enable/mode mismatch and bad enable code
      wr_ent(9, 40'hB0_0000_0000, 40'hFF_0000_0000, 2'd0, 2'd2, 8'h00, 2'd0, 1'b1, "R8 reject nonsplit shared");
      wr_ent(9, 40'hB0_0000_0000, 40'hFF_0000_0000, 2'd1, 2'd1, 8'h00, 2'd0, 1'b1, "R8 reject split whole");
      wr_ent(9, 40'hB0_0000_0000, 40'hFF_0000_0000, 2'd0, 2'd3, 8'h00, 2'd0, 1'b1, "R8 reject code3");
      // R9 geometry
      wr_ent(12, 40'hA0_0000_0000, 40'hFF_0F00_0000, 2'd0, 2'd1, 8'h00, 2'd0, 1'b1, "R9 reject noncontig");
      wr_ent(8,  40'h80_0100_0000, 40'hFF_0000_0000, 2'd0, 2'd1, 8'h00, 2'd0, 1'b1, "R9 reject misaligned");
      wr_ent(13, 40'hA0_0000_0000, 40'hFF_FFFF_FFF0, 2'd0, 2'd1, 8'h00, 2'd0, 1'b1, "R9 reject too small");
      // R10 rejected overwrite keeps entry, pulse lasts one cycle
      wr_ent(1, 40'h20_0000_0000, 40'hFF_FFF0_0000, 2'd1, 2'd2, 8'h77, 2'd0, 1'b1, "R10 reject overwrite");
      @(negedge clk);
      chk(cfg_err == 1'b0, "R10 single pulse", longint'(cfg_err), 0);
      look(40'h20_01FF_FFFF, 1'b1, 8'h5A, 4'd1, "R10 entry unchanged");
      // R6 live table update
      wr_seg(2, 5, 8'h33);
      look(40'h30_000A_0000, 1'b1, 8'h33, 4'd2, "R6 table rewrite");
      // R8 disable accepted, window stops matching
      wr_ent(3, 40'h00_0000_0000, 40'h00_0000_0000, 2'd0, 2'd0, 8'h00, 2'd0, 1'b0, "R8 disable accepted");
      look(40'h40_0004_0000, 1'b0, 8'h00, 4'd0, "R8 disabled window misses");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule